// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

This block is one timer channel that produces two pulse-width waveforms, A and B. Both come from a single up-counter that returns to zero on its own when it reaches the period value. Each output has a duty compare value and three two-bit action fields. The fields say what happens to its level when the counter matches the duty value, when the counter matches the period value, and when software fires a trigger. Each action can be none, set, clear or toggle. Both outputs share the period and the clock choice.

Software drives the channel through a small register bus. A mode word holds the action fields and a clock-source selector. The selector picks one of several prescaled clock-enable ticks or a slow tick. A command word starts the channel, stops it and fires the software trigger. The trigger restarts the counter and forces each output to its trigger level.

Normal polarity clears on the duty match and sets on the period match; inverted polarity does the opposite. A duty of zero, or a duty equal to the period, is programmed with no compare actions. The output then holds the trigger level alone.

Top module: `wt_dual_timer`

## Requirements
- R1: After reset the counter is 0, the channel is stopped, both outputs are low, and the mode word reads 0, which means every action is none and the selector is 0.
- R2: Register addresses are 0 for command/status, 1 for mode, 2 for duty A, 3 for duty B, 4 for period and 5 for the counter (read-only). Reads are 32 bits wide. Duty and period keep only their low CNT_W bits, and the upper bits read as zero. The mode word keeps only bits 11:0 and the selector field at bits 18:16; its other bits read as zero. Status bit 0 shows whether the channel is running.
- R3: Command bit 0 starts the channel, bit 1 stops it and bit 2 fires the software trigger. When start and stop are written together, stop wins.
- R4: Selector code k below N_DIV picks tick_div[k]. Code N_DIV picks tick_slow. Any larger code picks no tick. The counter advances only on cycles where the channel is running and the selected tick is high, and otherwise holds its value.
- R5: On an advancing cycle where the counter equals the period, it goes to 0. On any other advancing cycle it goes up by one.
- R6: A software trigger sets the counter to 0 and applies each output's trigger action at the same clock edge, whether or not the channel is running. It does not change the run state unless stop is written with it.
- R7: Action codes are 0 none, 1 set, 2 clear and 3 toggle. For output A the duty field is mode bits 1:0, the period field bits 3:2 and the trigger field bits 5:4. Output B uses bits 7:6, 9:8 and 11:10 for the same three fields. On an advancing cycle, a counter equal to the output's duty value applies its duty action, and a counter equal to the period applies its period action.
- R8: When the duty and period matches of one output coincide, only the period action takes effect. A software trigger overrides both.
- R9: With trigger set, duty clear and period set, after every edge since the trigger the output equals (count <= duty), for 0 < duty < period. The inverted settings give the complement.
- R10: With all compare actions none, an output keeps its trigger level for as long as the channel runs. This covers a duty of zero (trigger clear) and a duty equal to the period (trigger set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Combinational read data for addr |
| tick_div | input | N_DIV | Prescaled clock-enable ticks |
| tick_slow | input | 1 | Slow clock-enable tick |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | CNT_W | Current counter value |

## Verification
Every result is due exactly one rising edge after its cause. This holds for register writes, commands, the trigger, and each selected tick that advances the counter or drives an output through a compare match. Read data is combinational and is due in the same cycle as the address. The bench changes inputs on the falling edge and samples one falling edge later, so each sample sees exactly one more edge. It then computes the expected counter as the edge count since the trigger, taken modulo period plus one, and derives each output level from that count.

// File: rtl/wt_pkg.sv
package wt_pkg;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_TGL  = 2'd3
   } act_e;

   // mode word layout (bus side)
   localparam int ACT_W      = 2;
   localparam int FLD_DUTY   = 0;
   localparam int FLD_PER    = 2;
   localparam int FLD_TRIG   = 4;
   localparam int OUT_STRIDE = 6;
   localparam int N_OUT      = 2;
   localparam int ACT_BITS   = N_OUT * OUT_STRIDE;
   localparam int SEL_LSB    = 16;

   // command word bits
   localparam int CMD_START = 0;
   localparam int CMD_STOP  = 1;
   localparam int CMD_TRIG  = 2;

   // register addresses
   localparam int ADR_CMD    = 0;
   localparam int ADR_MODE   = 1;
   localparam int ADR_DUTY_A = 2;
   localparam int ADR_DUTY_B = 3;
   localparam int ADR_PERIOD = 4;
   localparam int ADR_COUNT  = 5;

   function automatic logic act_apply(act_e a, logic cur);
      logic r;
      unique case (a)
         ACT_SET: r = 1'b1;
         ACT_CLR: r = 1'b0;
         ACT_TGL: r = ~cur;
         default: r = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/wt_regs.sv
module wt_regs
   import wt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 3,
   parameter int SEL_W  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [BUS_W-1:0]          wdata,
   input  logic [CNT_W-1:0]          cnt,
   input  logic                      run,
   output logic [BUS_W-1:0]          rdata,
   output logic [ACT_BITS-1:0]       act_q,
   output logic [SEL_W-1:0]          sel_q,
   output logic [N_OUT-1:0][CNT_W-1:0] duty_q,
   output logic [CNT_W-1:0]          period_q,
   output logic                      cmd_start,
   output logic                      cmd_stop,
   output logic                      cmd_trig
);

   localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(ADR_CMD);
   localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADR_MODE);
   localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(ADR_PERIOD);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(ADR_COUNT);

   logic wr_cmd, wr_mode, wr_per;

   assign wr_cmd  = wr_en && (addr == A_CMD);
   assign wr_mode = wr_en && (addr == A_MODE);
   assign wr_per  = wr_en && (addr == A_PERIOD);

   assign cmd_start = wr_cmd & wdata[CMD_START];
   assign cmd_stop  = wr_cmd & wdata[CMD_STOP];
   assign cmd_trig  = wr_cmd & wdata[CMD_TRIG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= '0;
         sel_q    <= '0;
         period_q <= '0;
      end else begin
         if (wr_mode) begin
            act_q <= wdata[ACT_BITS-1:0];
            sel_q <= wdata[SEL_LSB +: SEL_W];
         end
         if (wr_per) period_q <= wdata[CNT_W-1:0];
      end
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_duty
      localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(ADR_DUTY_A + o);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            duty_q[o] <= '0;
         else if (wr_en && (addr == A_DUTY))
            duty_q[o] <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_CMD:    rdata[0] = run;
         A_MODE: begin
            rdata[ACT_BITS-1:0]    = act_q;
            rdata[SEL_LSB +: SEL_W] = sel_q;
         end
         ADDR_W'(ADR_DUTY_A): rdata[CNT_W-1:0] = duty_q[0];
         ADDR_W'(ADR_DUTY_B): rdata[CNT_W-1:0] = duty_q[1];
         A_PERIOD: rdata[CNT_W-1:0] = period_q;
         A_COUNT:  rdata[CNT_W-1:0] = cnt;
         default:  rdata = '0;
      endcase
   end

   // R2
   mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mode |=> $stable(act_q) && $stable(sel_q));

endmodule

// File: rtl/wt_tick_sel.sv
module wt_tick_sel #(
   parameter int N_SRC = 5,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] srcs,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   if ((2 ** SEL_W) == N_SRC) begin : g_full
      // every code maps to a source: plain index
      assign tick = srcs[sel];
   end else begin : g_sparse
      logic [N_SRC-1:0] hit;
      for (genvar k = 0; k < N_SRC; k++) begin : g_src
         assign hit[k] = srcs[k] && (sel == SEL_W'(k));
      end
      assign tick = |hit;
   end

   // R4
   no_src_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(sel) >= N_SRC) |-> !tick);

   // R4
   tick_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (srcs != '0));

endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             stop,
   input  logic             trig,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             run,
   output logic             step
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign step = run & tick & ~trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else begin
         if (stop)
            run <= 1'b0;
         else if (start)
            run <= 1'b1;

         if (trig)
            cnt <= '0;
         else if (step)
            cnt <= (cnt == period) ? '0 : cnt + ONE;
      end
   end

   // R3
   stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !run);

   // R3
   start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop) |=> run);

   // R6
   trig_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (cnt == '0));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run || !tick) && !trig) |=> $stable(cnt));

   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !trig && cnt == period) |=> (cnt == '0));

endmodule

// File: rtl/wt_out_ctl.sv
module wt_out_ctl
   import wt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] period,
   input  act_e             act_duty,
   input  act_e             act_per,
   input  act_e             act_trig,
   output logic             level
);

   logic hit_duty, hit_per, lvl_nx;

   assign hit_duty = step && (cnt == duty);
   assign hit_per  = step && (cnt == period);

   // trigger first, then period, then duty
   always_comb begin
      if (trig)
         lvl_nx = act_apply(act_trig, level);
      else if (hit_per)
         lvl_nx = act_apply(act_per, level);
      else if (hit_duty)
         lvl_nx = act_apply(act_duty, level);
      else
         lvl_nx = level;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= 1'b0;
      else        level <= lvl_nx;
   end

   // R6
   trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && act_trig == ACT_SET) |=> level);

   // R6
   trig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && act_trig == ACT_CLR) |=> !level);

   // R8
   per_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig && hit_per && act_per == ACT_NONE) |=> $stable(level));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig && !step) |=> $stable(level));

endmodule

// File: rtl/wt_dual_timer.sv
module wt_dual_timer
   import wt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 3,
   parameter int N_DIV  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic [N_DIV-1:0]  tick_div,
   input  logic              tick_slow,
   output logic              out_a,
   output logic              out_b,
   output logic [CNT_W-1:0]  count
);

   localparam int N_SRC = N_DIV + 1;
   localparam int SEL_W = $clog2(N_SRC);

   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("CNT_W must lie between 2 and BUS_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end
   if (N_DIV < 1 || SEL_W > 3 || BUS_W < SEL_LSB + SEL_W) begin : g_bad_sel
      $error("selector field does not fit the mode word");
   end

   logic [ACT_BITS-1:0]         act_q;
   logic [SEL_W-1:0]            sel_q;
   logic [N_OUT-1:0][CNT_W-1:0] duty_q;
   logic [CNT_W-1:0]            period_q, cnt;
   logic                        cmd_start, cmd_stop, cmd_trig;
   logic                        run, step, tick;
   logic [N_OUT-1:0]            lvl;

   wt_regs #(
      .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .cnt(cnt), .run(run), .rdata(rdata), .act_q(act_q), .sel_q(sel_q),
      .duty_q(duty_q), .period_q(period_q), .cmd_start(cmd_start),
      .cmd_stop(cmd_stop), .cmd_trig(cmd_trig)
   );

   wt_tick_sel #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .srcs({tick_slow, tick_div}),
      .sel(sel_q), .tick(tick)
   );

   wt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(cmd_start),
      .stop(cmd_stop), .trig(cmd_trig), .period(period_q),
      .cnt(cnt), .run(run), .step(step)
   );

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      localparam int B = o * OUT_STRIDE;
      wt_out_ctl #(.CNT_W(CNT_W)) u_out (
         .clk(clk), .rst_n(rst_n), .trig(cmd_trig), .step(step),
         .cnt(cnt), .duty(duty_q[o]), .period(period_q),
         .act_duty(act_e'(act_q[B + FLD_DUTY +: ACT_W])),
         .act_per (act_e'(act_q[B + FLD_PER  +: ACT_W])),
         .act_trig(act_e'(act_q[B + FLD_TRIG +: ACT_W])),
         .level(lvl[o])
      );
   end

   assign out_a = lvl[0];
   assign out_b = lvl[1];
   assign count = cnt;

   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (cnt == '0) && !run && (lvl == '0));

endmodule

// File: tb/tb_wt_dual_timer.sv
`timescale 1ns/1ps
module tb_wt_dual_timer;

   localparam int CNT_W = 16;
   localparam int BUS_W = 32;
   localparam int ADDR_W = 3;
   localparam int N_DIV = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [BUS_W-1:0]  wdata = '0;
   logic [BUS_W-1:0]  rdata;
   logic [N_DIV-1:0]  tick_div = '0;
   logic              tick_slow = 1'b0;
   logic              out_a, out_b;
   logic [CNT_W-1:0]  count;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   wt_dual_timer #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .N_DIV(N_DIV)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tick_div(tick_div), .tick_slow(tick_slow),
      .out_a(out_a), .out_b(out_b), .count(count)
   );

   localparam logic [1:0] NON = 2'd0, SET = 2'd1, CLR = 2'd2, TGL = 2'd3;

   function automatic logic [31:0] mk_mode(int sel, logic [1:0] ad, logic [1:0] ap,
                                           logic [1:0] at, logic [1:0] bd,
                                           logic [1:0] bp, logic [1:0] bt);
      return (32'(sel) << 16) | 32'(ad) | (32'(ap) << 2) | (32'(at) << 4) |
             (32'(bd) << 6) | (32'(bp) << 8) | (32'(bt) << 10);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns one falling edge later
   task automatic wr(int a, logic [31:0] d);
      wr_en = 1'b1;
      addr  = ADDR_W'(a);
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      addr = ADDR_W'(a);
      #1;
      d = rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 out_a", 32'(out_a), 0);
      check("R1 out_b", 32'(out_b), 0);
      check("R1 count", 32'(count), 0);
      rd(1, v); check("R1 mode", v, 0);
      rd(0, v); check("R1 status", v, 0);

      // R2 register widths
      wr(4, 32'hFFFF_FFFF); rd(4, v); check("R2 period", v, 32'h0000_FFFF);
      wr(1, 32'hFFFF_FFFF); rd(1, v); check("R2 mode", v, 32'h0007_0FFF);
      wr(2, 32'hABCD_1234); rd(2, v); check("R2 duty_a", v, 32'h0000_1234);
      wr(3, 32'h5555_00AA); rd(3, v); check("R2 duty_b", v, 32'h0000_00AA);
      wr(1, 0);

      // R3 commands
      wr(0, 1); rd(0, v); check("R3 start", v, 1);
      wr(0, 3); rd(0, v); check("R3 stop wins", v, 0);
      wr(0, 1); rd(0, v); check("R3 restart", v, 1);
      wr(0, 2); rd(0, v); check("R3 stop", v, 0);

      // R4 clock selector sweep
      wr(4, 100);
      for (int sel = 0; sel <= N_DIV + 1; sel++) begin
         for (int src = 0; src <= N_DIV; src++) begin
            tick_div = '0; tick_slow = 1'b0;
            wr(1, mk_mode(sel, NON, NON, NON, NON, NON, NON));
            wr(0, 5);
            if (src == N_DIV) tick_slow = 1'b1;
            else tick_div[src] = 1'b1;
            repeat (3) @(negedge clk);
            tick_div = '0; tick_slow = 1'b0;
            check($sformatf("R4 sel=%0d src=%0d", sel, src), 32'(count),
                  (sel == src) ? 3 : 0);
         end
      end
      // R4 hold while stopped
      wr(1, mk_mode(0, NON, NON, NON, NON, NON, NON));
      wr(0, 5);
      tick_div = 4'b0001;
      repeat (3) @(negedge clk);
      tick_div = '0;
      wr(0, 2);
      tick_div = 4'b0001;
      repeat (4) @(negedge clk);
      check("R4 stopped hold", 32'(count), 3);
      rd(5, v); check("R2 count readback", v, 3);

      // R5 R7 R9 waveform sweep: A normal, B inverted
      tick_div = 4'b0001;
      for (int d = 1; d <= 4; d++) begin
         wr(2, d);
         wr(3, 5 - d);
         wr(4, 5);
         wr(1, mk_mode(0, CLR, SET, SET, SET, CLR, CLR));
         wr(0, 5);
         for (int n = 0; n <= 13; n++) begin
            int c;
            if (n > 0) @(negedge clk);
            c = n % 6;
            check($sformatf("R5 count d=%0d n=%0d", d, n), 32'(count), c);
            check($sformatf("R9 out_a d=%0d n=%0d", d, n), 32'(out_a), 32'(c <= d));
            check($sformatf("R9 out_b d=%0d n=%0d", d, n), 32'(out_b), 32'(!(c <= 5 - d)));
         end
      end

      // R8 coincident duty and period
      wr(2, 4); wr(4, 4);
      wr(1, mk_mode(0, CLR, SET, CLR, NON, NON, NON));
      wr(0, 5);
      for (int n = 1; n <= 9; n++) begin
         @(negedge clk);
         if (n == 4) check("R8 before wrap", 32'(out_a), 0);
         if (n == 5) check("R8 period wins", 32'(out_a), 1);
      end
      check("R8 count at 4", 32'(count), 4);
      wr(0, 4);
      check("R8 trigger overrides", 32'(out_a), 0);
      check("R6 trigger restarts", 32'(count), 0);

      // R10 constant levels
      wr(2, 0); wr(3, 4); wr(4, 4);
      wr(1, mk_mode(0, NON, NON, CLR, NON, NON, SET));
      wr(0, 5);
      for (int n = 0; n < 12; n++) begin
         if (n > 0) @(negedge clk);
         check("R10 duty zero", 32'(out_a), 0);
         check("R10 duty full", 32'(out_b), 1);
      end

      // R7 toggle on period (A) and on duty (B)
      wr(2, 0); wr(3, 1); wr(4, 3);
      wr(1, mk_mode(0, NON, TGL, SET, TGL, NON, CLR));
      wr(0, 5);
      for (int n = 1; n <= 16; n++) begin
         @(negedge clk);
         check($sformatf("R7 toggle A n=%0d", n), 32'(out_a), 32'(1 ^ ((n / 4) % 2)));
         check($sformatf("R7 toggle B n=%0d", n), 32'(out_b), 32'(((n + 2) / 4) % 2));
      end

      // R6 stop with trigger, then trigger while stopped
      wr(1, mk_mode(0, NON, NON, CLR, NON, NON, SET));
      wr(0, 6);
      rd(0, v); check("R6 stop+trig stops", v, 0);
      check("R6 stop+trig count", 32'(count), 0);
      check("R6 stop+trig a", 32'(out_a), 0);
      check("R6 stop+trig b", 32'(out_b), 1);
      wr(1, mk_mode(0, NON, NON, SET, NON, NON, CLR));
      wr(0, 4);
      check("R6 stopped trig a", 32'(out_a), 1);
      check("R6 stopped trig b", 32'(out_b), 0);
      rd(0, v); check("R6 still stopped", v, 0);
      repeat (3) @(negedge clk);
      check("R6 count held", 32'(count), 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule